// File: doc/BRIEF.md
# Floating-Point Status Register with Compare Queue

This block keeps the 32-bit status word of a floating-point unit. The arithmetic datapath reports each finished operation with a strobe and a 5-bit exception vector. The block folds that vector into sticky bits at the top of the word. It raises a trap request when a newly reported exception has its enable bit set in the low five bits of the word.

Compare operations report one of four relations: greater, less, equal or unordered. A 5-bit selector picks which relation stores a 1. The stored bit goes to one of two places. It can be pushed into a shifting queue whose head is bit 26. It can also be written to a single slot chosen by a 3-bit index.

Software can load the whole word at once. The current word also drives the rounding-mode output and the flush-to-zero output of the datapath.

Top module: `fpsr_unit`

## Requirements
- R1: After a synchronous reset, the status word is 0 and trap_req is 0.
- R2: On sw_we, the status word equals sw_wdata from the next cycle. This write overrides any operation flags or compare in the same cycle, and no trap is raised in that cycle.
- R3: round_mode equals status bits 10:9, encoded as 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R4: flush_en equals status bit 5.
- R5: On op_done with a nonzero op_flags vector, flag bit i (0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid) is ORed into status bit 27+i. The sticky bits stay set, and all other bits are unchanged.
- R6: On op_done with op_flags equal to 0, the status word is unchanged and no trap is raised.
- R7: trap_req is a one-cycle pulse. It is set in the cycle after an op_done whose op_flags share a set bit with status bits 4:0 as they stood before the update.
- R8: The compare bit is cmp_sel[4] for greater (cmp_rel=0), cmp_sel[3] for less (1), cmp_sel[2] for equal (2) and cmp_sel[1] for unordered (3). cmp_sel[0] has no effect on the stored bit.
- R9: A compare with cmp_idx=0 moves bits 21:12 into 20:11 and the old bit 26 into bit 21, then writes the compare bit into bit 26.
- R10: A compare with a nonzero cmp_idx y writes only bit 22-y, and the queue does not shift.
- R11: When op_done and cmp_valid arrive in the same cycle, the flags are merged first and the compare is applied to the merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software load strobe |
| sw_wdata | input | 32 | Word loaded by software |
| op_done | input | 1 | Arithmetic operation finished |
| op_flags | input | 5 | Exception vector of that operation |
| cmp_valid | input | 1 | Compare result valid |
| cmp_rel | input | 2 | Relation: 0 greater, 1 less, 2 equal, 3 unordered |
| cmp_sel | input | 5 | Condition selector |
| cmp_idx | input | 3 | 0 pushes to queue, 1..7 writes one slot |
| status | output | 32 | Current status word |
| round_mode | output | 2 | Decoded rounding mode |
| flush_en | output | 1 | Flush denormals to zero |
| trap_req | output | 1 | Trap request pulse |

## Verification
The bench targets the queue shift. A design that shifts the wrong way, or drops the old head into bit 21, gives a wrong word after three pushes in a row. It checks the slot index at both ends, 1 and 7. An off-by-one there lands the bit next to the intended one. It separates the trap condition from the sticky bits: a flag whose enable is clear must not trap, and an enabled flag must trap exactly once. The same-cycle cases check that a software write wins with no trap, and that a merge combined with a push yields both effects.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
    localparam int WORD_W   = 32;
    localparam int NFLAGS   = 5;
    localparam int STICKY_LO = 27;
    localparam int QHEAD    = 26;
    localparam int QTAIL_HI = 21;
    localparam int QTAIL_LO = 11;
    localparam int RM_LO    = 9;
    localparam int FLUSH_B  = 5;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rmode_e;

    typedef struct packed {
        logic        valid;
        rel_e        rel;
        logic [4:0]  sel;
        logic [2:0]  idx;
    } cmp_req_t;

    function automatic logic pick_cond(rel_e r, logic [4:0] s);
        case (r)
            REL_GT:  return s[4];
            REL_LT:  return s[3];
            REL_EQ:  return s[2];
            default: return s[1];
        endcase
    endfunction
endpackage

// File: rtl/fpsr_flag_merge.sv
module fpsr_flag_merge
    import fpsr_pkg::*;
#(
    parameter int NF = NFLAGS
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic              done,
    input  logic [NF-1:0]     flags,
    output logic [WORD_W-1:0] word_out,
    output logic              trap
);
    localparam int TOP = STICKY_LO + NF - 1;

    always_comb begin
        word_out = word_in;
        trap     = 1'b0;
        if (done && (flags != '0)) begin
            word_out[TOP:STICKY_LO] = word_in[TOP:STICKY_LO] | flags;
            trap = |(flags & word_in[NF-1:0]);
        end
    end
endmodule

// File: rtl/fpsr_cmp_queue.sv
module fpsr_cmp_queue
    import fpsr_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  cmp_req_t          req,
    output logic [WORD_W-1:0] word_out
);
    logic cbit;
    int   slot;

    always_comb begin
        cbit     = pick_cond(req.rel, req.sel);
        slot     = QTAIL_HI + 1 - int'(req.idx);
        word_out = word_in;
        if (req.valid) begin
            if (req.idx == '0) begin
                word_out[QTAIL_HI-1:QTAIL_LO] = word_in[QTAIL_HI:QTAIL_LO+1];
                word_out[QTAIL_HI]            = word_in[QHEAD];
                word_out[QHEAD]               = cbit;
            end else begin
                word_out[slot] = cbit;
            end
        end
    end
endmodule

// File: rtl/fpsr_mode_decode.sv
module fpsr_mode_decode
    import fpsr_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output rmode_e            rmode,
    output logic              flush
);
    always_comb begin
        rmode = rmode_e'(word[RM_LO+1:RM_LO]);
        flush = word[FLUSH_B];
    end
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
    import fpsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_we,
    input  logic [31:0] sw_wdata,
    input  logic        op_done,
    input  logic [4:0]  op_flags,
    input  logic        cmp_valid,
    input  logic [1:0]  cmp_rel,
    input  logic [4:0]  cmp_sel,
    input  logic [2:0]  cmp_idx,
    output logic [31:0] status,
    output logic [1:0]  round_mode,
    output logic        flush_en,
    output logic        trap_req
);
    logic [WORD_W-1:0] stat_q, merged, queued;
    logic              trap_c;
    cmp_req_t          creq;
    rmode_e            rm;

    assign creq = '{valid: cmp_valid, rel: rel_e'(cmp_rel), sel: cmp_sel, idx: cmp_idx};

    fpsr_flag_merge #(.NF(NFLAGS)) u_merge (
        .word_in(stat_q), .done(op_done), .flags(op_flags),
        .word_out(merged), .trap(trap_c)
    );

    fpsr_cmp_queue u_queue (
        .word_in(merged), .req(creq), .word_out(queued)
    );

    fpsr_mode_decode u_dec (
        .word(stat_q), .rmode(rm), .flush(flush_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q   <= '0;
            trap_req <= 1'b0;
        end else if (sw_we) begin
            stat_q   <= sw_wdata;
            trap_req <= 1'b0;
        end else begin
            stat_q   <= queued;
            trap_req <= trap_c;
        end
    end

    assign status     = stat_q;
    assign round_mode = rm;

    // R2
    sw_load_chk: assert property (@(posedge clk) disable iff (rst)
        sw_we |=> (status == $past(sw_wdata)) && !trap_req);

    // R5
    sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
        (op_done && !sw_we) |=> ((status[31:27] & $past(op_flags)) == $past(op_flags)));

    // R6
    zero_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (op_done && op_flags == 5'd0 && !sw_we && !cmp_valid) |=> ($stable(status) && !trap_req));

    // R7
    trap_src_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> $past(op_done && !sw_we && op_flags != 5'd0));

    // R9
    queue_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_idx == 3'd0 && !sw_we && !op_done) |=>
        (status[20:11] == $past(status[21:12])) && (status[21] == $past(status[26])));

    // R10
    slot_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_idx != 3'd0 && !sw_we && !op_done) |=>
        (status[31:22] == $past(status[31:22])) && (status[10:0] == $past(status[10:0])));
endmodule

// File: tb/fpsr_unit_tb_top.sv
module fpsr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        sw_we;
    logic [31:0] sw_wdata;
    logic        op_done;
    logic [4:0]  op_flags;
    logic        cmp_valid;
    logic [1:0]  cmp_rel;
    logic [4:0]  cmp_sel;
    logic [2:0]  cmp_idx;
    logic [31:0] status;
    logic [1:0]  round_mode;
    logic        flush_en;
    logic        trap_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fpsr_unit dut_i (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .op_done(op_done), .op_flags(op_flags), .cmp_valid(cmp_valid),
        .cmp_rel(cmp_rel), .cmp_sel(cmp_sel), .cmp_idx(cmp_idx),
        .status(status), .round_mode(round_mode), .flush_en(flush_en),
        .trap_req(trap_req)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        sw_we = 0; sw_wdata = '0; op_done = 0; op_flags = '0;
        cmp_valid = 0; cmp_rel = '0; cmp_sel = '0; cmp_idx = '0;
    endtask

    // Inputs set at a falling edge are held across one rising edge and cleared at the next falling edge.
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic swr(logic [31:0] v);
        sw_we = 1; sw_wdata = v; step();
    endtask

    task automatic op(logic [4:0] f);
        op_done = 1; op_flags = f; step();
    endtask

    task automatic cmp(logic [1:0] r, logic [4:0] s, logic [2:0] i);
        cmp_valid = 1; cmp_rel = r; cmp_sel = s; cmp_idx = i; step();
    endtask

    task automatic t_reset();
        check("R1 status", status, 32'h0);
        check("R1 trap", {31'd0, trap_req}, 32'd0);
    endtask

    task automatic t_load_modes();
        swr(32'hA5A5_0621);
        check("R2 load", status, 32'hA5A5_0621);
        check("R3 mode down", {30'd0, round_mode}, 32'd3);
        check("R4 flush on", {31'd0, flush_en}, 32'd1);
        swr(32'h0000_0200);
        check("R3 mode zero", {30'd0, round_mode}, 32'd1);
        check("R4 flush off", {31'd0, flush_en}, 32'd0);
        swr(32'h0000_0400);
        check("R3 mode up", {30'd0, round_mode}, 32'd2);
    endtask

    task automatic t_sticky();
        swr(32'h0);
        op(5'b00101);
        check("R5 merge", status, 32'h2800_0000);
        check("R7 no enable", {31'd0, trap_req}, 32'd0);
        op(5'b10000);
        check("R5 sticky", status, 32'hA800_0000);
        op(5'b00000);
        check("R6 unchanged", status, 32'hA800_0000);
        check("R6 no trap", {31'd0, trap_req}, 32'd0);
    endtask

    task automatic t_trap();
        swr(32'h0000_0004);
        op(5'b00010);
        check("R7 disabled flag", {31'd0, trap_req}, 32'd0);
        check("R5 underflow bit", status, 32'h1000_0004);
        op(5'b00100);
        check("R7 trap", {31'd0, trap_req}, 32'd1);
        check("R5 overflow bit", status, 32'h3000_0004);
        step();
        check("R7 pulse ends", {31'd0, trap_req}, 32'd0);
    endtask

    task automatic t_queue();
        swr(32'h0);
        cmp(2'd0, 5'b10000, 3'd0);
        check("R9 push1", status, 32'h0400_0000);
        cmp(2'd2, 5'b00100, 3'd0);
        check("R9 push2", status, 32'h0420_0000);
        cmp(2'd1, 5'b10000, 3'd0);
        check("R9 R8 push3", status, 32'h0030_0000);
    endtask

    task automatic t_slots();
        swr(32'h0);
        cmp(2'd3, 5'b00011, 3'd1);
        check("R10 R8 slot1", status, 32'h0020_0000);
        swr(32'hFFFF_FFFF);
        cmp(2'd0, 5'b01111, 3'd7);
        check("R10 R8 slot7", status, 32'hFFFF_7FFF);
        swr(32'h0);
        cmp(2'd1, 5'b00001, 3'd3);
        check("R8 sel0 ignored", status, 32'h0);
        cmp(2'd1, 5'b01000, 3'd3);
        check("R10 slot3", status, 32'h0008_0000);
    endtask

    task automatic t_priority();
        swr(32'h0000_001F);
        sw_we = 1; sw_wdata = 32'h0000_001F;
        op_done = 1; op_flags = 5'b11111;
        cmp_valid = 1; cmp_rel = 2'd0; cmp_sel = 5'b10000; cmp_idx = 3'd0;
        step();
        check("R2 priority", status, 32'h0000_001F);
        check("R2 no trap", {31'd0, trap_req}, 32'd0);
    endtask

    task automatic t_combined();
        swr(32'h0000_001F);
        op_done = 1; op_flags = 5'b00001;
        cmp_valid = 1; cmp_rel = 2'd0; cmp_sel = 5'b10000; cmp_idx = 3'd0;
        step();
        check("R11 merge and push", status, 32'h0C00_001F);
        check("R11 trap", {31'd0, trap_req}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_load_modes();
        t_sticky();
        t_trap();
        t_queue();
        t_slots();
        t_priority();
        t_combined();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule